// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block sits on the host side of a parallel NOR flash device and works out when an internal program or erase operation has ended and whether it ended well. Software or a command sequencer first launches the operation. It then pulses `start` with a method select, the address to watch and, for the data method, the byte that was written. The poller reads from the device one byte at a time over a request/acknowledge read port. It inspects the status bits that come back and ends with a single `done` pulse. At that pulse exactly one of `pass`, `fail` or `timeout` is raised and held.

Two methods are offered. In the data method a read is complete when its bit 7 equals bit 7 of the expected byte. In the toggle method a pair of reads is complete when bit 6 reads the same both times. In either method bit 5 reports that the device has flagged an error, and the poller then takes confirming reads before it gives a verdict. A device that never settles is cut off after a parameterised number of polling rounds. This is reported as a timeout, which is kept separate from a failure.

Top module: `flash_done_poller`

## Requirements
- R1: After reset `busy`, `done`, `rd_req`, `pass`, `fail` and `timeout` are all 0.
- R2: With `mode`=0 (data method), a returned byte whose bit 7 equals bit 7 of `expect_data` ends the operation with `pass`.
- R3: In the data method, a byte whose bit 7 differs from the expected bit 7 while its bit 5 is 0 causes another read of the same address.
- R4: In the data method, a byte whose bit 7 differs while bit 5 is 1 causes exactly one confirming read. The result is `pass` if that byte's bit 7 matches the expected bit 7 and `fail` otherwise.
- R5: With `mode`=1 (toggle method), reads are taken in pairs. If bit 6 is equal in both reads of a pair, the result is `pass`.
- R6: In the toggle method, if bit 6 differs within a pair and bit 5 of the first read of the pair is 0, a new pair is read.
- R7: In the toggle method, if bit 6 differs within a pair and bit 5 of the first read is 1, two further reads are taken. The result is `pass` if their bit 6 values are equal and `fail` if they differ.
- R8: A polling round is one read in the data method and one pair in the toggle method. Confirming reads are not counted as rounds. If round number MAX_ITER would loop back, the poller ends with `timeout`=1 and `pass`=`fail`=0. A round that completes is still honoured, including round number MAX_ITER.
- R9: At most one read is outstanding. `rd_req` stays high with `rd_addr` equal to the latched poll address until `rd_ack` is seen, and it is low in the cycle after the acknowledge.
- R10: `done` is high for exactly one cycle. When it rises exactly one of `pass`/`fail`/`timeout` is 1, and all three hold their values until the cycle after the next accepted `start`, when they are cleared.
- R11: `start` is accepted only while `busy` is 0. A start while busy changes neither the address read, the method, the reads taken nor the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin polling (accepted when idle) |
| mode | input | 1 | 0 = data method, 1 = toggle method |
| poll_addr | input | AW | Address to read while polling |
| expect_data | input | 8 | Byte written by the operation (bit 7 used) |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read acknowledge, `rd_data` valid with it |
| rd_data | input | 8 | Byte returned by the device |
| busy | output | 1 | Polling in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Operation finished successfully |
| fail | output | 1 | Operation reported an error |
| timeout | output | 1 | Round limit reached without a verdict |

## Verification
The completion pulse of one operation and the acceptance of the next `start` can land in the same cycle. The bench provokes this by raising `start` in the very cycle it sees `done`. It then judges that the new operation begins, that `busy` returns at once and that the old verdict is cleared one cycle later. A second collision happens when an acknowledge arrives in the same cycle as a start that the poller should ignore. Both cases are compared on every clock against a behavioural model of the bus and result timing.

// File: rtl/fpoll_pkg.sv
package fpoll_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_MAIN  = 3'd1,
    PH_TOG2  = 3'd2,
    PH_CONF1 = 3'd3,
    PH_CONF2 = 3'd4
  } phase_e;

  typedef enum logic {
    MODE_DATA   = 1'b0,
    MODE_TOGGLE = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    RES_NONE    = 2'd0,
    RES_PASS    = 2'd1,
    RES_FAIL    = 2'd2,
    RES_TIMEOUT = 2'd3
  } result_e;

  localparam int BIT_POLL  = 7;
  localparam int BIT_TOG   = 6;
  localparam int BIT_ERR   = 5;

endpackage

// File: rtl/fpoll_rst_sync.sv
module fpoll_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/fpoll_rd_port.sv
module fpoll_rd_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic          rd_ack,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic [DW-1:0] byte_q,
  output logic          byte_vld
);

  logic          req_q, req_d;
  logic          vld_d;
  logic          cap_en;
  logic [DW-1:0] byte_d;

  always_comb begin
    cap_en = req_q & rd_ack;
    if (req_q) begin
      req_d = ~rd_ack;
    end else begin
      req_d = issue;
    end
    vld_d  = cap_en;
    byte_d = cap_en ? rd_data : byte_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      byte_vld <= 1'b0;
    end else begin
      req_q    <= req_d;
      byte_vld <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
    end else if (cap_en) begin
      byte_q <= byte_d;
    end
  end

  assign rd_req = req_q;

endmodule

// File: rtl/fpoll_iter_cnt.sv
module fpoll_iter_cnt #(
  parameter int MAX_ITER = 16,
  localparam int CW = $clog2(MAX_ITER + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_limit
);

  localparam logic [CW-1:0] LAST = CW'(MAX_ITER - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt      = cnt_q;
  assign at_limit = (cnt_q == LAST);

endmodule

// File: rtl/fpoll_ctrl.sv
module fpoll_ctrl
  import fpoll_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [AW-1:0] poll_addr,
  input  logic [7:0]    expect_data,
  input  logic          byte_vld,
  input  logic [7:0]    byte_q,
  input  logic          at_limit,
  output logic          issue,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          timeout
);

  phase_e        phase_q, phase_d;
  mode_e         mode_q;
  logic          exp7_q;
  logic [AW-1:0] addr_q;
  logic          samp6_q, samp6_d;
  logic          samp5_q, samp5_d;
  logic          samp_en;
  logic          latch_en;
  result_e       res_q, res_d;
  logic          res_en;
  logic          finish;
  logic          done_q;
  logic          d_poll, d_tog, d_err;
  logic          unused_bits;

  assign d_poll      = byte_q[BIT_POLL];
  assign d_tog       = byte_q[BIT_TOG];
  assign d_err       = byte_q[BIT_ERR];
  assign unused_bits = ^{byte_q[4:0], expect_data[6:0]};

  always_comb begin
    phase_d  = phase_q;
    issue    = 1'b0;
    cnt_clr  = 1'b0;
    cnt_inc  = 1'b0;
    finish   = 1'b0;
    res_d    = res_q;
    latch_en = 1'b0;
    samp_en  = 1'b0;
    samp6_d  = samp6_q;
    samp5_d  = samp5_q;

    if (phase_q == PH_IDLE) begin
      if (start) begin
        latch_en = 1'b1;
        cnt_clr  = 1'b1;
        issue    = 1'b1;
        phase_d  = PH_MAIN;
        res_d    = RES_NONE;
      end
    end else if (byte_vld) begin
      unique case (phase_q)
        PH_MAIN: begin
          if (mode_q == MODE_DATA) begin
            if (d_poll == exp7_q) begin
              finish = 1'b1;
              res_d  = RES_PASS;
            end else if (d_err) begin
              issue   = 1'b1;
              phase_d = PH_CONF1;
            end else if (at_limit) begin
              finish = 1'b1;
              res_d  = RES_TIMEOUT;
            end else begin
              cnt_inc = 1'b1;
              issue   = 1'b1;
            end
          end else begin
            samp_en = 1'b1;
            samp6_d = d_tog;
            samp5_d = d_err;
            issue   = 1'b1;
            phase_d = PH_TOG2;
          end
        end
        PH_TOG2: begin
          if (d_tog == samp6_q) begin
            finish = 1'b1;
            res_d  = RES_PASS;
          end else if (samp5_q) begin
            issue   = 1'b1;
            phase_d = PH_CONF1;
          end else if (at_limit) begin
            finish = 1'b1;
            res_d  = RES_TIMEOUT;
          end else begin
            cnt_inc = 1'b1;
            issue   = 1'b1;
            phase_d = PH_MAIN;
          end
        end
        PH_CONF1: begin
          if (mode_q == MODE_DATA) begin
            finish = 1'b1;
            res_d  = (d_poll == exp7_q) ? RES_PASS : RES_FAIL;
          end else begin
            samp_en = 1'b1;
            samp6_d = d_tog;
            issue   = 1'b1;
            phase_d = PH_CONF2;
          end
        end
        PH_CONF2: begin
          finish = 1'b1;
          res_d  = (d_tog == samp6_q) ? RES_PASS : RES_FAIL;
        end
        default: begin
          phase_d = PH_IDLE;
        end
      endcase
    end

    if (finish) begin
      phase_d = PH_IDLE;
    end
    res_en = latch_en | finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_DATA;
      exp7_q <= 1'b0;
      addr_q <= '0;
    end else if (latch_en) begin
      mode_q <= mode_e'(mode);
      exp7_q <= expect_data[BIT_POLL];
      addr_q <= poll_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp6_q <= 1'b0;
      samp5_q <= 1'b0;
    end else if (samp_en) begin
      samp6_q <= samp6_d;
      samp5_q <= samp5_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= RES_NONE;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign rd_addr = addr_q;
  assign busy    = (phase_q != PH_IDLE);
  assign done    = done_q;
  assign pass    = (res_q == RES_PASS);
  assign fail    = (res_q == RES_FAIL);
  assign timeout = (res_q == RES_TIMEOUT);

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int AW       = 19,
  parameter int MAX_ITER = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode,
  input  logic [AW-1:0] poll_addr,
  input  logic [7:0]    expect_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_ack,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          timeout
);

  localparam int CW = $clog2(MAX_ITER + 1);

  logic          rst_n_sync;
  logic          issue;
  logic          byte_vld;
  logic [7:0]    byte_q;
  logic          cnt_clr;
  logic          cnt_inc;
  logic          at_limit;
  logic [CW-1:0] iter_cnt;

  fpoll_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  fpoll_rd_port #(.DW(8)) u_rd_port (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .issue    (issue),
    .rd_ack   (rd_ack),
    .rd_data  (rd_data),
    .rd_req   (rd_req),
    .byte_q   (byte_q),
    .byte_vld (byte_vld)
  );

  fpoll_iter_cnt #(.MAX_ITER(MAX_ITER)) u_iter (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .cnt      (iter_cnt),
    .at_limit (at_limit)
  );

  fpoll_ctrl #(.AW(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .start       (start),
    .mode        (mode),
    .poll_addr   (poll_addr),
    .expect_data (expect_data),
    .byte_vld    (byte_vld),
    .byte_q      (byte_q),
    .at_limit    (at_limit),
    .issue       (issue),
    .cnt_clr     (cnt_clr),
    .cnt_inc     (cnt_inc),
    .rd_addr     (rd_addr),
    .busy        (busy),
    .done        (done),
    .pass        (pass),
    .fail        (fail),
    .timeout     (timeout)
  );

endmodule

// File: rtl/fpoll_chk.sv
module fpoll_chk #(
  parameter int AW       = 19,
  parameter int MAX_ITER = 16,
  localparam int CW = $clog2(MAX_ITER + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic          timeout,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic [CW-1:0] iter_cnt
);

  // R9: request held until acknowledged
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req);

  // R9: request drops after the acknowledge
  a_r9_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && rd_ack |=> !rd_req);

  // R9: address steady while a read waits
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> $stable(rd_addr));

  // R11: reads happen only during an operation
  a_r11_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: exactly one verdict at completion
  a_r10_done_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({pass, fail, timeout}) == 1));

  // R10: verdicts never overlap
  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pass, fail, timeout}));

  // R10: verdict held while idle and no start
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable({pass, fail, timeout}));

  // R8: round counter never passes the limit
  a_r8_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(iter_cnt) < MAX_ITER);

endmodule

bind flash_done_poller fpoll_chk #(.AW(AW), .MAX_ITER(MAX_ITER)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .pass     (pass),
  .fail     (fail),
  .timeout  (timeout),
  .rd_req   (rd_req),
  .rd_ack   (rd_ack),
  .rd_addr  (rd_addr),
  .iter_cnt (iter_cnt)
);

// File: tb/flash_done_poller_tb.sv
`timescale 1ns/1ps
module flash_done_poller_tb;

  localparam int AW   = 19;
  localparam int MAXI = 5;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          mode;
  logic [AW-1:0] poll_addr;
  logic [7:0]    expect_data;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_ack;
  logic [7:0]    rd_data;
  logic          busy, done, pass, fail, timeout;

  int tests;
  int fails;
  int cycles;

  flash_done_poller #(.AW(AW), .MAX_ITER(MAXI)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .poll_addr(poll_addr), .expect_data(expect_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .busy(busy), .done(done), .pass(pass), .fail(fail), .timeout(timeout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [7:0] dev_q[$];
  int ack_dly;
  int wait_cnt;
  int n_reads;

  always @(negedge clk) begin
    if (rd_req && rst_n) begin
      if (wait_cnt >= ack_dly) begin
        rd_ack   = 1'b1;
        rd_data  = (dev_q.size() > 0) ? dev_q.pop_front() : 8'h00;
        n_reads  = n_reads + 1;
        wait_cnt = 0;
      end else begin
        rd_ack   = 1'b0;
        wait_cnt = wait_cnt + 1;
      end
    end else begin
      rd_ack = 1'b0;
    end
  end

  // ---------------- reference model ----------------
  bit m_busy, m_req, m_done, m_pass, m_fail, m_to, m_have;
  bit m_mode, m_exp7, m_s6, m_s5;
  logic [AW-1:0] m_addr;
  logic [7:0] m_byte;
  int m_stage, m_iter;

  task automatic m_finish(input int r);
    m_busy = 0; m_done = 1;
    m_pass = (r == 1); m_fail = (r == 2); m_to = (r == 3);
  endtask

  task automatic m_loop(input int next_stage);
    if (m_iter == MAXI - 1) m_finish(3);
    else begin m_iter++; m_req = 1; m_stage = next_stage; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_req = 0; m_done = 0; m_pass = 0; m_fail = 0; m_to = 0;
      m_have = 0; m_stage = 0; m_iter = 0; m_addr = '0;
    end else begin
      bit was_busy, cap;
      logic [7:0] cb;
      was_busy = m_busy;
      cap = m_req && rd_ack;
      cb = rd_data;
      m_done = 0;
      if (cap) m_req = 0;
      if (m_have) begin
        bit b7, b6, b5;
        b7 = m_byte[7]; b6 = m_byte[6]; b5 = m_byte[5];
        case (m_stage)
          0: if (!m_mode) begin
               if (b7 == m_exp7) m_finish(1);
               else if (b5) begin m_req = 1; m_stage = 2; end
               else m_loop(0);
             end else begin
               m_s6 = b6; m_s5 = b5; m_req = 1; m_stage = 1;
             end
          1: if (b6 == m_s6) m_finish(1);
             else if (m_s5) begin m_req = 1; m_stage = 2; end
             else m_loop(0);
          2: if (!m_mode) m_finish((b7 == m_exp7) ? 1 : 2);
             else begin m_s6 = b6; m_req = 1; m_stage = 3; end
          default: m_finish((b6 == m_s6) ? 1 : 2);
        endcase
      end
      if (!was_busy && start) begin
        m_busy = 1; m_req = 1; m_pass = 0; m_fail = 0; m_to = 0;
        m_mode = mode; m_exp7 = expect_data[7]; m_addr = poll_addr;
        m_stage = 0; m_iter = 0;
      end
      m_have = cap;
      if (cap) m_byte = cb;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      logic [5:0] act, exp;
      act = {busy, done, pass, fail, timeout, rd_req};
      exp = {m_busy, m_done, m_pass, m_fail, m_to, m_req};
      check(act == exp, "R10/R9/R11 cycle model", 32'(act), 32'(exp));
      if (rd_req && m_req)
        check(rd_addr == m_addr, "R9 rd_addr", 32'(rd_addr), 32'(m_addr));
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic start_op(input bit md, input logic [AW-1:0] a, input logic [7:0] e);
    start = 1'b1; mode = md; poll_addr = a; expect_data = e;
    n_reads = 0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic push(input logic [7:0] b);
    dev_q.push_back(b);
  endtask

  // result code: 1 pass, 2 fail, 3 timeout
  task automatic expect_end(input int res, input int reads, input string tag);
    bit seen;
    logic [2:0] got, want;
    wait_done(seen);
    check(seen, {tag, " done seen"}, 32'(seen), 1);
    got  = {pass, fail, timeout};
    want = {res == 1, res == 2, res == 3};
    check(got == want, {tag, " verdict"}, 32'(got), 32'(want));
    check(n_reads == reads, {tag, " read count"}, 32'(n_reads), 32'(reads));
  endtask

  task automatic run(input bit md, input logic [7:0] e, input int dly,
                     input int res, input int reads, input string tag);
    ack_dly = dly;
    start_op(md, 19'h1234A, e);
    expect_end(res, reads, tag);
    @(negedge clk);
    dev_q.delete();
  endtask

  initial begin
    tests = 0; fails = 0; cycles = 0;
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; poll_addr = '0; expect_data = '0;
    rd_ack = 1'b0; rd_data = '0; ack_dly = 0; wait_cnt = 0; n_reads = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check({busy, done, rd_req, pass, fail, timeout} == 6'b0, "R1 reset state",
          32'({busy, done, rd_req, pass, fail, timeout}), 0);

    // R2: match on first read
    push(8'hA5);
    run(0, 8'hA5, 0, 1, 1, "R2 immediate");
    // R2: expected bit 7 is 0
    push(8'h7F);
    run(0, 8'h00, 2, 1, 1, "R2 exp bit7 zero");
    // R3: two misses then match
    push(8'h05); push(8'h01); push(8'h85);
    run(0, 8'hA5, 1, 1, 3, "R3 reread");
    // R4: error then confirm match
    push(8'h20); push(8'h85);
    run(0, 8'hA5, 0, 1, 2, "R4 confirm pass");
    // R4: error then confirm miss
    push(8'h20); push(8'h20);
    run(0, 8'hA5, 3, 2, 2, "R4 confirm fail");
    // R8: completes on last allowed round
    for (int i = 0; i < MAXI - 1; i++) push(8'h00);
    push(8'h80);
    run(0, 8'hA5, 0, 1, MAXI, "R8 last round pass");
    // R8: data method timeout
    for (int i = 0; i < MAXI + 3; i++) push(8'h00);
    run(0, 8'hA5, 0, 3, MAXI, "R8 data timeout");

    // R5: stable pair
    push(8'h40); push(8'h40);
    run(1, 8'h00, 0, 1, 2, "R5 stable pair");
    // R6: toggling pair then stable pair
    push(8'h40); push(8'h00); push(8'h00); push(8'h00);
    run(1, 8'h00, 2, 1, 4, "R6 repeat pair");
    // R7: error and settled
    push(8'h60); push(8'h00); push(8'h44); push(8'h44);
    run(1, 8'h00, 0, 1, 4, "R7 confirm pass");
    // R7: error and still toggling
    push(8'h60); push(8'h00); push(8'h40); push(8'h00);
    run(1, 8'h00, 1, 2, 4, "R7 confirm fail");
    // R8: toggle timeout, MAXI pairs
    for (int i = 0; i < MAXI + 2; i++) begin push(8'h40); push(8'h00); end
    run(1, 8'h00, 0, 3, 2 * MAXI, "R8 toggle timeout");

    // R11: start while busy is ignored
    push(8'h00); push(8'h00); push(8'hA5);
    ack_dly = 3;
    start_op(0, 19'h00777, 8'hA5);
    repeat (2) @(negedge clk);
    start = 1'b1; mode = 1'b1; poll_addr = 19'h7FFFF; expect_data = 8'h00;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    expect_end(1, 3, "R11 busy start ignored");
    check(rd_addr == 19'h00777, "R11 address kept", 32'(rd_addr), 32'h777);
    dev_q.delete();

    // R10: verdict held while idle
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(pass && !done && !busy, "R10 verdict held", 32'({pass, done, busy}), 32'h4);

    // R10: back-to-back start in the done cycle
    push(8'h20); push(8'h20);
    ack_dly = 0;
    start_op(0, 19'h00100, 8'hA5);
    begin
      bit seen;
      wait_done(seen);
      check(seen && fail, "R10 first op fail", 32'({seen, fail}), 32'h3);
      push(8'h80);
      start_op(0, 19'h00200, 8'h80);
      check(busy && !fail && !pass, "R10 cleared on new start",
            32'({busy, fail, pass}), 32'h4);
      expect_end(1, 1, "R10 chained op");
    end
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule